// File: doc/BRIEF.md
# Receive Payload Byte Queue with Overrun Recovery

This block sits behind a frame start detector in a radio receiver. Once the detector reports a recognised start pattern, the block takes the following payload bits, packs them into bytes and queues them in a 16-entry byte FIFO. The host pulls bytes out one at a time through a read strobe. The head byte is always visible on the read data port. Empty, full and overrun status are available at the ports, and the full status can drive an interrupt line when the host selects it.

A small capture state machine controls when bits are taken. It has two states. In HUNT it waits for a start; in FILL it packs bits. These transitions exist:
- HUNT stays in HUNT until a start pulse arrives, then moves to FILL.
- FILL stays in FILL while bits are captured.
- FILL returns to HUNT on a host re-arm request or on an overrun clear.

The `hunting` output is high in HUNT and tells the start detector to search again. When a byte completes while the queue is full, that byte is lost and a sticky overrun flag is set. The host recovers by writing a one to the overrun flag, modelled here as the `ovr_clr` pulse. This empties the queue, clears all status and sends the machine back to HUNT.

Top module: `rx_payload_fifo`

## Requirements
- R1: After reset, fifo_empty=1, fifo_full=0, fifo_overrun=0, irq_out=0 and hunting=1.
- R2: In HUNT, bit_vld is ignored. A start_hit pulse moves the machine to FILL, so hunting reads 0 one cycle later. A bit presented in the same cycle as start_hit is not captured.
- R3: In FILL, bits are packed MSB first: the first captured bit lands in bit 7. A byte is queued by the clock edge that samples its eighth bit, and fifo_empty falls at that edge.
- R4: Bytes leave in arrival order. rd_data always shows the oldest byte, and rd_en=1 removes it. rd_en while the queue is empty has no effect.
- R5: fifo_full is 1 exactly while 16 bytes are held.
- R6: If a byte completes while 16 bytes are held and rd_en is 0, that byte is discarded. fifo_overrun is then set and stays set, and the held bytes are unchanged.
- R7: A read and a byte completion in the same cycle are both accepted and the occupancy is unchanged, including when the queue is full. No overrun is raised in that case.
- R8: An ovr_clr pulse empties the queue, clears fifo_full and fifo_overrun, and puts the machine in HUNT. It takes priority over a read, a completing byte and a start pulse in the same cycle.
- R9: A rearm pulse returns the machine to HUNT and discards any partly packed byte, while queued bytes are kept.
- R10: irq_out equals fifo_full when irq_sel is 2'b01 and is 0 for every other irq_sel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Recovered payload bit |
| bit_vld | input | 1 | bit_in is valid this cycle |
| start_hit | input | 1 | Start pattern recognised (one-cycle pulse) |
| rearm | input | 1 | Host request to stop capture and search again |
| ovr_clr | input | 1 | Host writes one to the overrun flag: flush and re-arm |
| rd_en | input | 1 | Remove the head byte |
| irq_sel | input | 2 | Interrupt routing select; 2'b01 routes the full flag |
| rd_data | output | 8 | Oldest queued byte |
| fifo_empty | output | 1 | No byte queued |
| fifo_full | output | 1 | 16 bytes queued |
| fifo_overrun | output | 1 | Sticky: a byte was discarded |
| irq_out | output | 1 | Interrupt line |
| hunting | output | 1 | Machine is in HUNT |

## Verification
A bit counter that is off by one shows up on the first payload byte. rd_data then reads a shifted value, or fifo_empty falls one bit early or late. A pointer or count fault appears within one pass of 16 bytes as a wrong byte order, a full flag at the wrong occupancy, or an overrun when none should occur. A state fault is seen on `hunting` one cycle after the start, re-arm or clear, and on the byte that follows a re-arm.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [0:0] {
        CAP_HUNT = 1'b0,
        CAP_FILL = 1'b1
    } cap_state_t;

    localparam logic [1:0] IRQ_SEL_FULL = 2'b01;
endpackage

// File: rtl/rxf_capture.sv
module rxf_capture
    import rxf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_vld,
    input  logic         start_hit,
    input  logic         rearm,
    input  logic         flush,
    output logic         byte_vld,
    output logic [W-1:0] byte_data,
    output logic         hunting
);
    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

    cap_state_t st_q, st_d;
    logic [W-2:0]    sh_q;
    logic [CNTW-1:0] cnt_q;
    logic            take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAP_HUNT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_HUNT: if (start_hit) st_d = CAP_FILL;
            CAP_FILL: st_d = CAP_FILL;
            default:  st_d = CAP_HUNT;
        endcase
        if (flush || rearm) st_d = CAP_HUNT;
    end

    assign take = (st_q == CAP_FILL) && bit_vld && !flush && !rearm;

    // bit packing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (st_q != CAP_FILL || flush || rearm) begin
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= {sh_q[W-3:0], bit_in};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNTW'(1);
        end
    end

    // outputs
    always_comb begin
        byte_vld  = take && (cnt_q == LAST);
        byte_data = {sh_q, bit_in};
        hunting   = (st_q == CAP_HUNT);
    end

    assert_start_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && start_hit && !rearm && !flush) |=> !hunting);
    assert_rearm_hunts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm || flush) |=> hunting);
    assert_hunt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hunting) && hunting |-> !byte_vld);
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          rd_fire, wr_fire;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CMAX);
    assign rd_fire = rd_req && !empty && !flush;
    assign wr_fire = wr_req && !flush && (!full || rd_fire);
    assign drop    = wr_req && !flush && !wr_fire;
    assign rd_data = mem[rp_q];

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_fire) wp_q <= (wp_q == PMAX) ? '0 : wp_q + AW'(1);
            if (rd_fire) rp_q <= (rp_q == PMAX) ? '0 : rp_q + AW'(1);
            unique case ({wr_fire, rd_fire})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req && !flush) |=> (full && $stable(rd_data)));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    assert_both_keep_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && !empty && !flush) |=> $stable(cnt_q));
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req) |=> empty);
endmodule

// File: rtl/rx_payload_fifo.sv
module rx_payload_fifo
    import rxf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              start_hit,
    input  logic              rearm,
    input  logic              ovr_clr,
    input  logic              rd_en,
    input  logic [1:0]        irq_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_overrun,
    output logic              irq_out,
    output logic              hunting
);
    logic              byte_vld;
    logic [DATA_W-1:0] byte_data;
    logic              drop;

    rxf_capture #(.W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .start_hit (start_hit),
        .rearm     (rearm),
        .flush     (ovr_clr),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .hunting   (hunting)
    );

    rxf_store #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (ovr_clr),
        .wr_req  (byte_vld),
        .wr_data (byte_data),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .drop    (drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fifo_overrun <= 1'b0;
        else if (ovr_clr) fifo_overrun <= 1'b0;
        else if (drop)    fifo_overrun <= 1'b1;
    end

    assign irq_out = fifo_full && (irq_sel == IRQ_SEL_FULL);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_overrun && !ovr_clr) |=> fifo_overrun);
    assert_clear_recovers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> (!fifo_overrun && fifo_empty && hunting));
    assert_irq_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> fifo_full);
    assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
endmodule

// File: tb/sim_rx_payload_fifo.sv
module sim_rx_payload_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0, bit_vld = 1'b0, start_hit = 1'b0, rearm = 1'b0;
    logic ovr_clr = 1'b0, rd_en = 1'b0;
    logic [1:0] irq_sel = 2'b00;
    logic [7:0] rd_data;
    logic fifo_empty, fifo_full, fifo_overrun, irq_out, hunting;

    int n_chk = 0, n_bad = 0;
    int mq [0:511];
    int mh = 0, mt = 0;
    logic exp_ovr = 1'b0;

    always #2 clk = ~clk;

    rx_payload_fifo u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .start_hit(start_hit), .rearm(rearm), .ovr_clr(ovr_clr), .rd_en(rd_en),
        .irq_sel(irq_sel), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_overrun(fifo_overrun), .irq_out(irq_out),
        .hunting(hunting)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int mcount();
        return mt - mh;
    endfunction

    function automatic logic [7:0] pat(int k);
        return 8'((k * 29 + 3) & 255);
    endfunction

    task automatic put_bit(logic b, logic rd);
        bit_in = b; bit_vld = 1'b1; rd_en = rd;
        @(negedge clk);
        bit_vld = 1'b0; rd_en = 1'b0;
    endtask

    // send a byte MSB first; rd_last reads in the cycle of the eighth bit
    task automatic send_byte(logic [7:0] v, logic rd_last);
        logic popped;
        for (int i = 7; i >= 0; i--) put_bit(v[i], rd_last && (i == 0));
        popped = rd_last && (mcount() > 0);
        if (popped) mh++;
        if (mcount() < 16) begin
            mq[mt] = int'(v); mt++;
        end else exp_ovr = 1'b1;
    endtask

    task automatic pop_check(string req);
        if (mcount() > 0) chk(req, int'(rd_data), mq[mh]);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (mcount() > 0) mh++;
    endtask

    task automatic pulse_start();
        start_hit = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        start_hit = 1'b0; bit_vld = 1'b0;
    endtask

    task automatic check_flags(string req);
        chk({req, " empty"}, int'(fifo_empty), int'(mcount() == 0));
        chk({req, " full"}, int'(fifo_full), int'(mcount() == 16));
        chk({req, " overrun"}, int'(fifo_overrun), int'(exp_ovr));
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", int'(fifo_empty), 1);
        chk("R1 full", int'(fifo_full), 0);
        chk("R1 overrun", int'(fifo_overrun), 0);
        chk("R1 irq", int'(irq_out), 0);
        chk("R1 hunting", int'(hunting), 1);

        // R2 bits ignored while hunting
        for (int i = 0; i < 16; i++) put_bit(1'(i & 1), 1'b0);
        chk("R2 ignored", int'(fifo_empty), 1);
        pulse_start();
        chk("R2 start", int'(hunting), 0);

        // R3 MSB-first packing, queued on the eighth bit
        for (int i = 7; i >= 1; i--) put_bit(1'((8'hA5 >> i) & 1), 1'b0);
        chk("R3 seven bits", int'(fifo_empty), 1);
        put_bit(1'b1, 1'b0);
        mq[mt] = 8'hA5; mt++;
        chk("R3 eighth bit", int'(fifo_empty), 0);
        chk("R3 value", int'(rd_data), 8'hA5);

        // R5 fill to 16 with R10 sweep along the way
        for (int k = 1; k < 16; k++) begin
            send_byte(pat(k), 1'b0);
            for (int s = 0; s < 4; s++) begin
                irq_sel = 2'(s);
                #1;
                chk("R10 irq", int'(irq_out), int'((s == 1) && (mcount() == 16)));
            end
            check_flags("R5");
        end
        chk("R5 full at 16", int'(fifo_full), 1);
        chk("R4 head kept", int'(rd_data), 8'hA5);

        // R6 drop when full
        send_byte(pat(16), 1'b0);
        check_flags("R6");
        chk("R6 head kept", int'(rd_data), 8'hA5);
        send_byte(pat(17), 1'b0);
        chk("R6 sticky", int'(fifo_overrun), 1);

        // R7 read and write in one cycle while full
        exp_ovr = 1'b1;
        send_byte(pat(18), 1'b1);
        check_flags("R7");
        chk("R7 head moved", int'(rd_data), mq[mh]);

        // R4 drain in order, then read while empty
        while (mcount() > 0) pop_check("R4 order");
        check_flags("R4");
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R4 empty read", int'(fifo_empty), 1);
        chk("R4 empty read ovr", int'(fifo_overrun), 1);

        // R8 clear: flush and re-arm
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        exp_ovr = 1'b0;
        check_flags("R8");
        chk("R8 hunting", int'(hunting), 1);
        for (int i = 0; i < 8; i++) put_bit(1'b1, 1'b0);
        chk("R8 bits ignored", int'(fifo_empty), 1);

        // R9 rearm drops partial byte, keeps queue
        pulse_start();
        for (int k = 0; k < 3; k++) send_byte(pat(40 + k), 1'b0);
        for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
        rearm = 1'b1; @(negedge clk); rearm = 1'b0;
        chk("R9 hunting", int'(hunting), 1);
        for (int i = 0; i < 8; i++) put_bit(1'b0, 1'b0);
        check_flags("R9");
        pulse_start();
        send_byte(8'h3C, 1'b0);
        chk("R9 count", int'(fifo_empty), 0);
        while (mcount() > 0) pop_check("R9 order");
        chk("R9 drained", int'(fifo_empty), 1);

        // R8 priority over read, completing byte and start
        pulse_start();
        for (int k = 0; k < 2; k++) send_byte(pat(60 + k), 1'b0);
        for (int i = 7; i >= 1; i--) put_bit(1'b1, 1'b0);
        bit_in = 1'b1; bit_vld = 1'b1; rd_en = 1'b1; ovr_clr = 1'b1; start_hit = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0; start_hit = 1'b0;
        mh = mt;
        check_flags("R8 priority");
        chk("R8 priority hunting", int'(hunting), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule